// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between a processor's load/store/fetch path and an external data bus whose peripheral ports can be 8, 16 or 32 bits wide. It takes one access request (address, kind, direction, write data) and splits it into as many bus cycles as the responding port needs. For every bus cycle it presents the cycle address, a two-bit code for the bytes still owed, the byte lanes a 32-bit decoder would enable, and write data copied onto the lanes so that a port of any width finds its byte where it expects it.

The port width is not configured. Each cycle ends with a two-line acknowledge, and its encoding tells the block how wide the port was. The number of bytes moved in that cycle follows from the width and the low address bits. The address then steps forward and the owed count shrinks, until nothing is left. Read bytes are gathered into an operand register, and a one-cycle done pulse presents the right-justified result.

The bus data path is numbered big-endian. Lane 3 is bits 31:24 and carries the byte at address offset 0 of a 32-bit word. Lane 0 is bits 7:0 and carries offset 3.

Top module: `dbs_sequencer`

## Requirements
- R1: The acknowledge `cyc_ack` is decoded as follows: `2'b11` means a 32-bit port, `2'b10` a 16-bit port and `2'b01` an 8-bit port. With `2'b00` the current cycle is held: `cyc_valid`, `cyc_addr` and `cyc_size` keep their values for as many clocks as the acknowledge stays away.
- R2: A byte access (`req_kind` = 2'b00) takes exactly one bus cycle at every alignment and every port width.
- R3: A word access (`req_kind` = 2'b01) takes the following number of cycles, given as 32/16/8-bit port. Offset 0: 1/1/2. Offset 1: 1/2/2. Offset 2: 1/1/2. Offset 3: 2/2/2.
- R4: A long-word access (`req_kind` = 2'b10) takes the following number of cycles, given as 32/16/8-bit port. Offset 0: 1/2/4. Offsets 1 and 3: 2/3/4. Offset 2: 2/2/4.
- R5: An instruction fetch (`req_kind` = 2'b11; bit 0 of the address is 0) behaves in one of two ways. At offset 0 it reads four bytes from the long-word-aligned address in 1/2/4 cycles. At offset 2 it reads only the two bytes at that address, in 1/1/2 cycles.
- R6: Every cycle after the first starts at the previous cycle's address plus the bytes that cycle moved. The number of bytes moved is the smaller of the bytes owed and the port width minus the address offset within the port. `cyc_size` gives the bytes still owed, modulo 4: 01 for 1, 10 for 2, 11 for 3, 00 for 4.
- R7: `cyc_lanes[3-k]` is set for every offset k from the cycle's address offset up to the lesser of that offset plus the bytes owed and 4. A single owed byte sets exactly one lane.
- R8: On writes, each port width finds the next operand byte in the lanes it uses. An 8-bit port uses lane 3. A 16-bit port uses lane 3 at an even address and lane 2 at an odd one. A 32-bit port uses lane 3 minus the offset. The bytes the port stores rebuild the operand, most significant byte at the lowest address.
- R9: After the final acknowledge of a read, `done` is high for one clock. In that clock `rd_operand` holds the bytes read, right-justified, with the lowest address most significant. `cyc_valid` is low and `req_ready` is high.
- R10: After reset, `req_ready` is 1 and `cyc_valid` and `done` are 0. A request is taken when `req_valid` and `req_ready` are both high. From the next clock, `req_ready` is low and `cyc_valid` is high until the access finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 00 byte, 01 word, 10 long word, 11 instruction fetch |
| req_write | input | 1 | 1 for a write access |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | 32 | Write operand, right-justified |
| cyc_valid | output | 1 | A bus cycle is in progress |
| cyc_write | output | 1 | Direction of the bus cycle |
| cyc_addr | output | AW | Address of the bus cycle |
| cyc_size | output | 2 | Bytes still owed, modulo 4 |
| cyc_lanes | output | 4 | Byte lanes enabled for a 32-bit decoder |
| cyc_wdata | output | 32 | Lane-replicated write data |
| cyc_ack | input | 2 | Cycle acknowledge carrying the port width |
| cyc_rdata | input | 32 | Read data from the port |
| done | output | 1 | One-clock completion pulse |
| rd_operand | output | 32 | Assembled read operand, right-justified |

## Verification
A wrong byte count or a stale address shows up in the same bus cycle, as an unexpected `cyc_addr` or `cyc_size`. It also shows up at completion, as a cycle count that differs from the per-width tables. A wrong transfer index lands a byte in the wrong operand position, which shows in `rd_operand` at the done pulse, or in the bytes a narrow port stores, which a responder memory model reveals right after the write. Every alignment is driven against every port width, some with wait states, so a fault that appears only for one offset or width still reaches the ports within a few clocks.

// File: rtl/dbs_pkg.sv
// Shared types and helpers for the dynamic bus sizing sequencer.
// Assumes a 32-bit data bus numbered big-endian: lane 3 = bits 31:24.
package dbs_pkg;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'b00,
        ACC_WORD  = 2'b01,
        ACC_LONG  = 2'b10,
        ACC_FETCH = 2'b11
    } acc_kind_e;

    // Byte k of a left-justified word (k = 0 is bits 31:24).
    function automatic logic [7:0] lane_byte(input logic [DW-1:0] w, input logic [1:0] k);
        return w[8*(3-k) +: 8];
    endfunction
endpackage

// File: rtl/dbs_port_decode.sv
// Turns the acknowledge code into a port width, the starting lane offset
// inside that port and the number of bytes this cycle moves.
// Assumes rem is 1..4 while a cycle is live; width 0 means no acknowledge.
module dbs_port_decode (
    input  logic [1:0] ack,
    input  logic [1:0] a_lo,
    input  logic [2:0] rem,
    output logic [2:0] width,
    output logic [1:0] base,
    output logic [2:0] take
);
    logic [2:0] room;

    // Decode width and offset of the address within the port.
    always_comb begin
        case (ack)
            2'b11:   begin width = 3'd4; base = a_lo;              end
            2'b10:   begin width = 3'd2; base = {1'b0, a_lo[0]};   end
            2'b01:   begin width = 3'd1; base = 2'b00;             end
            default: begin width = 3'd0; base = 2'b00;             end
        endcase
    end

    // Bytes moved: what is owed, capped by what the port can still reach.
    always_comb begin
        room = width - {1'b0, base};
        take = (rem < room) ? rem : room;
    end
endmodule

// File: rtl/dbs_lane_steer.sv
// Produces the 32-bit lane enables and replicates write bytes so an
// 8-, 16- or 32-bit port each finds the next operand byte on its lanes.
// Assumes wbuf holds the operand left-justified and j counts bytes sent.
module dbs_lane_steer
    import dbs_pkg::*;
(
    input  logic [DW-1:0] wbuf,
    input  logic [1:0]    j,
    input  logic [1:0]    a_lo,
    input  logic [2:0]    rem,
    output logic [NB-1:0] lanes,
    output logic [DW-1:0] wlane
);
    for (genvar L = 0; L < NB; L++) begin : g_lane
        localparam logic [2:0] OFF = 3'(NB - 1 - L);
        logic [1:0] idx;

        // Enable a lane when its offset lies inside the owed window.
        assign lanes[L] = (OFF >= {1'b0, a_lo}) && (OFF < ({1'b0, a_lo} + rem));

        if (L == NB - 1) begin : g_top
            // Uppermost lane serves every narrow port: always the next byte.
            assign idx = j;
        end else if (L == NB - 2) begin : g_half
            // Second lane: next byte for an odd 16-bit address, else the one after.
            assign idx = j + {1'b0, ~a_lo[0]};
        end else begin : g_full
            // Lower lanes are reached only by a 32-bit port.
            assign idx = j + 2'(OFF) - a_lo;
        end

        assign wlane[8*L +: 8] = lane_byte(wbuf, idx);
    end
endmodule

// File: rtl/dbs_read_pack.sv
// Copies the bytes a read cycle returned into the left-justified
// operand buffer, at positions following the bytes already gathered.
// Assumes base + take never exceeds four lanes.
module dbs_read_pack
    import dbs_pkg::*;
(
    input  logic [DW-1:0] rbuf,
    input  logic [DW-1:0] rdata,
    input  logic [1:0]    j,
    input  logic [1:0]    base,
    input  logic [2:0]    take,
    output logic [DW-1:0] nbuf
);
    logic [1:0] dst;
    logic [1:0] src;

    // Place each received byte at operand index j+i from lane 3-base-i.
    always_comb begin
        nbuf = rbuf;
        dst  = 2'b00;
        src  = 2'b00;
        for (int i = 0; i < NB; i++) begin
            if (3'(i) < take) begin
                dst = j + 2'(i);
                src = 2'd3 - base - 2'(i);
                nbuf[8*(3-dst) +: 8] = rdata[8*src +: 8];
            end
        end
    end
endmodule

// File: rtl/dbs_sequencer.sv
// Dynamic bus sizing sequencer: splits one access into bus cycles sized
// by the width each acknowledge reports, and gathers read data.
// Assumes fetch addresses are even and requests arrive only when ready.
module dbs_sequencer
    import dbs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          cyc_valid,
    output logic          cyc_write,
    output logic [AW-1:0] cyc_addr,
    output logic [1:0]    cyc_size,
    output logic [NB-1:0] cyc_lanes,
    output logic [DW-1:0] cyc_wdata,
    input  logic [1:0]    cyc_ack,
    input  logic [DW-1:0] cyc_rdata,
    output logic          done,
    output logic [DW-1:0] rd_operand
);
    logic          busy, wr;
    logic [AW-1:0] addr, ld_addr;
    logic [2:0]    rem, tot, ld_tot;
    logic [1:0]    j;
    logic [DW-1:0] wbuf, rbuf, nbuf;
    logic [2:0]    width, take;
    logic [1:0]    base;
    acc_kind_e     kind;

    assign kind = acc_kind_e'(req_kind);

    dbs_port_decode u_dec (
        .ack(cyc_ack), .a_lo(addr[1:0]), .rem(rem),
        .width(width), .base(base), .take(take)
    );

    dbs_lane_steer u_steer (
        .wbuf(wbuf), .j(j), .a_lo(addr[1:0]), .rem(rem),
        .lanes(cyc_lanes), .wlane(cyc_wdata)
    );

    dbs_read_pack u_pack (
        .rbuf(rbuf), .rdata(cyc_rdata), .j(j), .base(base), .take(take),
        .nbuf(nbuf)
    );

    // Start address and total byte count of an incoming request.
    always_comb begin
        ld_addr = req_addr;
        case (kind)
            ACC_BYTE: ld_tot = 3'd1;
            ACC_WORD: ld_tot = 3'd2;
            ACC_LONG: ld_tot = 3'd4;
            default: begin
                ld_tot = req_addr[1] ? 3'd2 : 3'd4;
                if (!req_addr[1]) ld_addr = {req_addr[AW-1:2], 2'b00};
            end
        endcase
    end

    // Sequencing state: load on accept, advance on every acknowledged cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            wr         <= 1'b0;
            addr       <= '0;
            rem        <= '0;
            tot        <= '0;
            j          <= '0;
            wbuf       <= '0;
            rbuf       <= '0;
            done       <= 1'b0;
            rd_operand <= '0;
        end else begin
            done <= 1'b0;
            if (!busy && req_valid) begin
                busy <= 1'b1;
                wr   <= req_write;
                addr <= ld_addr;
                rem  <= ld_tot;
                tot  <= ld_tot;
                j    <= 2'b00;
                rbuf <= '0;
                wbuf <= req_wdata << {3'd4 - ld_tot, 3'b000};
            end else if (busy && width != 3'd0) begin
                addr <= addr + AW'(take);
                rem  <= rem - take;
                j    <= j + take[1:0];
                rbuf <= nbuf;
                if (rem == take) begin
                    busy       <= 1'b0;
                    done       <= 1'b1;
                    rd_operand <= nbuf >> {3'd4 - tot, 3'b000};
                end
            end
        end
    end

    assign req_ready = !busy;
    assign cyc_valid = busy;
    assign cyc_write = wr;
    assign cyc_addr  = addr;
    assign cyc_size  = rem[1:0];
endmodule

// File: rtl/dbs_sequencer_chk.sv
// Protocol checker for dbs_sequencer, attached by bind below.
// Assumes the same reset and clock as the sequencer.
module dbs_sequencer_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          cyc_valid,
    input logic [AW-1:0] cyc_addr,
    input logic [1:0]    cyc_size,
    input logic [3:0]    cyc_lanes,
    input logic [1:0]    cyc_ack,
    input logic          done
);
    // R1
    hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_ack == 2'b00) |=> (cyc_valid && $stable(cyc_addr) && $stable(cyc_size)));

    // R7
    single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_size == 2'b01) |-> ($countones(cyc_lanes) == 1));

    // R7
    lanes_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_lanes != 4'b0000));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cyc_valid && req_ready));

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cyc_valid && !req_ready));
endmodule

bind dbs_sequencer dbs_sequencer_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_size(cyc_size),
    .cyc_lanes(cyc_lanes), .cyc_ack(cyc_ack), .done(done)
);

// File: tb/tb_dbs_sequencer.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected bus cycles into a queue, a
// responder pops and compares them while acting as a sized port.
module tb_dbs_sequencer;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        cyc_valid, cyc_write;
    logic [31:0] cyc_addr;
    logic [1:0]  cyc_size;
    logic [3:0]  cyc_lanes;
    logic [31:0] cyc_wdata;
    logic [1:0]  cyc_ack = 2'b00;
    logic [31:0] cyc_rdata = '0;
    logic        done;
    logic [31:0] rd_operand;

    always #2.5 clk = ~clk;

    dbs_sequencer #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
        .cyc_addr(cyc_addr), .cyc_size(cyc_size), .cyc_lanes(cyc_lanes),
        .cyc_wdata(cyc_wdata), .cyc_ack(cyc_ack), .cyc_rdata(cyc_rdata),
        .done(done), .rd_operand(rd_operand)
    );

    typedef struct {
        logic [31:0] addr;
        logic [1:0]  sz;
        logic [3:0]  ln;
        int          n;
    } cyc_t;

    cyc_t       expq[$];
    logic [7:0] mem[64];
    int total = 0, bad = 0;
    int cur_pw = 4, cur_ws = 0, wcnt = 0, acks = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_cyc(int kind, int a, int pw);
        case (kind)
            0: return 1;
            1: if (pw == 4) return (a == 3) ? 2 : 1;
               else if (pw == 2) return (a % 2 == 1) ? 2 : 1;
               else return 2;
            2: if (pw == 4) return (a == 0) ? 1 : 2;
               else if (pw == 2) return (a == 0 || a == 2) ? 2 : 3;
               else return 4;
            default: if (a >= 2) return (pw == 1) ? 2 : 1;
                     else return 4 / pw;
        endcase
    endfunction

    // Responder: waits ws clocks, then checks the cycle and acknowledges.
    always @(negedge clk) begin
        cyc_ack   = 2'b00;
        cyc_rdata = {4{8'hEE}};
        if (rst_n && cyc_valid) begin
            if (expq.size() == 0) begin
                chk("R6 unexpected cycle", cyc_addr, 32'hFFFF_FFFF);
            end else if (wcnt < cur_ws) begin
                wcnt++;
                chk("R1 held address", cyc_addr, expq[0].addr);
            end else begin
                cyc_t e;
                int   a6;
                e = expq.pop_front();
                wcnt = 0;
                acks++;
                chk("R6 address", cyc_addr, e.addr);
                chk("R6 size code", 32'(cyc_size), 32'(e.sz));
                chk("R7 lanes", 32'(cyc_lanes), 32'(e.ln));
                a6 = int'(cyc_addr[5:0]);
                cyc_ack = (cur_pw == 4) ? 2'b11 : (cur_pw == 2) ? 2'b10 : 2'b01;
                if (cur_pw == 4) begin
                    for (int L = 0; L < 4; L++) cyc_rdata[8*L +: 8] = mem[(a6 & ~3) + 3 - L];
                end else if (cur_pw == 2) begin
                    cyc_rdata[31:24] = mem[a6 & ~1];
                    cyc_rdata[23:16] = mem[a6 | 1];
                end else begin
                    cyc_rdata[31:24] = mem[a6];
                end
                if (cyc_write) begin
                    for (int i = 0; i < e.n; i++) begin
                        int lane;
                        lane = (cur_pw == 4) ? 3 - ((a6 % 4) + i) :
                               (cur_pw == 2) ? 3 - ((a6 % 2) + i) : 3;
                        mem[a6 + i] = cyc_wdata[8*lane +: 8];
                    end
                end
            end
        end
    end

    task automatic run_acc(input int kind, input int a, input bit wr, input int pw,
                           input int ws, input int slot);
        int start, tot, cur, rem, off, n, guard, base, exp_n;
        logic [31:0] wd, expv;
        cyc_t e;
        string ctag;
        base = 8 + 4 * (slot % 8);
        if (kind == 3) begin
            tot   = (a >= 2) ? 2 : 4;
            start = (a >= 2) ? base + 2 : base;
        end else begin
            tot   = 1 << kind;
            start = base + a;
        end
        cur = start;
        rem = tot;
        while (rem > 0) begin
            off = (pw == 4) ? cur % 4 : (pw == 2) ? cur % 2 : 0;
            n = (rem < pw - off) ? rem : pw - off;
            e.addr = 32'(cur);
            e.sz   = 2'(rem % 4);
            e.ln   = 4'b0000;
            for (int k = cur % 4; k < 4 && k < (cur % 4) + rem; k++) e.ln[3-k] = 1'b1;
            e.n = n;
            expq.push_back(e);
            cur += n;
            rem -= n;
        end
        wd   = 32'h9C3B_5E71 ^ (32'(slot) * 32'h0107_0B0D);
        expv = '0;
        for (int k = 0; k < tot; k++) expv = (expv << 8) | 32'(mem[start + k]);
        cur_pw = pw;
        cur_ws = ws;
        acks   = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_write = wr;
        req_addr  = 32'(base + a);
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 busy after accept", 32'(req_ready), 32'd0);
        guard = 0;
        while (!done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        exp_n = exp_cyc(kind, a, pw);
        ctag = (kind == 0) ? "R2 cycles" : (kind == 1) ? "R3 cycles" :
               (kind == 2) ? "R4 cycles" : "R5 cycles";
        chk(ctag, 32'(acks), 32'(exp_n));
        chk("R9 done pulse", 32'(done), 32'd1);
        chk("R9 ready at done", 32'(req_ready), 32'd1);
        if (!wr) begin
            chk("R9 read operand", rd_operand, expv);
        end else begin
            for (int k = 0; k < tot; k++)
                chk("R8 stored byte", 32'(mem[start + k]), 32'(wd[8*(tot-1-k) +: 8]));
        end
        chk("R6 all cycles issued", 32'(expq.size()), 32'd0);
        expq.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int slot;
        int pws[3];
        pws = '{4, 2, 1};
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        chk("R10 reset ready", 32'(req_ready), 32'd1);
        chk("R10 reset cyc_valid", 32'(cyc_valid), 32'd0);
        chk("R10 reset done", 32'(done), 32'd0);
        rst_n = 1'b1;
        slot = 0;
        for (int kind = 0; kind < 3; kind++)
            for (int a = 0; a < 4; a++)
                for (int p = 0; p < 3; p++)
                    for (int w = 0; w < 2; w++) begin
                        run_acc(kind, a, w[0], pws[p], (a + kind + w) % 3, slot);
                        slot++;
                    end
        for (int a = 0; a < 4; a += 2)
            for (int p = 0; p < 3; p++) begin
                run_acc(3, a, 1'b0, pws[p], p % 2, slot);
                slot++;
            end
        repeat (2) @(negedge clk);
        chk("R9 done is a single pulse", 32'(done), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule